// File: doc/BRIEF.md
# Measurement Mode Sequencer

This block decides when a three-axis magnetic sensor front end takes a measurement, and what happens to the result. A 2-bit mode field selects free-running, one-shot, idle or sleep behaviour. A configuration pair selects the output rate and the bias test pattern. The sequencer talks to an abstract converter through a start strobe, an axis select and a done/data/overflow return. It walks the axes in the order X, Y, Z and drives the bias polarity lines during biased conversions. When all three axes are finished, it updates all three result registers at once.

In bias (self-test) operation, every axis is converted twice: first with the drive off, then with the drive on. The stored result is the biased value minus the unbiased one. A converter overflow, a value outside the 12-bit signed range, or a difference outside that range stores the marker value -4096 (0xF000). The bus master has priority: while `bus_busy` is high, no conversion is started. A one-shot measurement rewrites the mode field to sleep once its results are stored. Any write to the mode or configuration registers abandons a sequence in progress and re-arms the rate timer.

Top module: `meas_sequencer`

## Requirements
- R1: After reset, `mode_field` reads 01 (one-shot), all results read 0 and `res_strobe` is low. A one-shot measurement then runs without any write.
- R2: In one-shot mode (01), the block converts axis 0, 1 and 2 in that order (`adc_axis` 0=X, 1=Y, 2=Z). It updates `res_x`/`res_y`/`res_z` together with a one-cycle `res_strobe`, and in that same cycle `mode_field` becomes 11 (sleep).
- R3: Writing mode 00 (continuous) arms a timer. The first `adc_start` of a sequence is high in the cycle that begins 2P+1 clock edges after the edge that samples the write. P = units × CLK_PER_UNIT clocks.
- R4: In continuous mode, later sequences start exactly P cycles apart.
- R5: Rate code to units: 000→400, 001→200, 010→100, 011→40, 100→20 (reset value), 101→10, 110→4. The unused code 111 behaves as 100.
- R6: In idle (10) and sleep (11) no `adc_start` is issued, and any pending timer request is dropped.
- R7: Bias code 01 drives X and Y positive and Z negative. Code 10 reverses all three polarities. Codes 00 and 11 are unbiased. `bias_drive` bit 0 means positive drive and bit 1 means negative drive. With bias active, each axis is converted first with `bias_drive`=00, then with the drive on, and the stored value is second minus first.
- R8: An axis stores -4096 if `adc_ovf` is set, if a converted value lies outside -2048..2047, or if the bias difference lies outside that range. The next valid measurement replaces it.
- R9: `adc_start` is never high while `bus_busy` is high. The conversion resumes once the bus is released.
- R10: A mode or configuration write during a sequence abandons it: no `res_strobe` follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | New mode value |
| cfg_wr | input | 1 | Write strobe for rate and bias configuration |
| cfg_rate | input | 3 | New output-rate code |
| cfg_bias | input | 2 | New bias code |
| bus_busy | input | 1 | Bus master access in progress; holds off conversions |
| adc_done | input | 1 | Converter result valid (one cycle) |
| adc_data | input | 16 | Converter result, two's complement |
| adc_ovf | input | 1 | Converter overflow/underflow flag with adc_done |
| adc_start | output | 1 | Conversion request (one cycle) |
| adc_axis | output | 2 | Axis of the current conversion |
| bias_drive | output | 2 | Bias polarity: bit0 positive, bit1 negative |
| mode_field | output | 2 | Current mode field |
| res_x | output | 16 | Stored X result |
| res_y | output | 16 | Stored Y result |
| res_z | output | 16 | Stored Z result |
| res_strobe | output | 1 | One-cycle pulse when all three results update |

## Verification
A wrong timer count shows up as the first continuous `adc_start` arriving early or late against the 2P+1 mark, and as the gap between sequences drifting from P. This is visible within one output period. A fault in the phase, axis or polarity state gives a wrong sign or a wrong magnitude on the first biased `res_strobe`. A wrong overflow decision gives a value other than 0xF000, or the marker where a real value belongs, on that same strobe. Mode-field errors show one cycle after a one-shot finishes, or as stray `adc_start` pulses while idle or sleeping.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int DATA_W    = 16;
    localparam int RES_BITS  = 12;
    localparam int AXES      = 3;
    localparam int MAX_UNITS = 400;

    typedef enum logic [1:0] {
        MODE_CONT   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_IDLE   = 2'b10,
        MODE_SLEEP  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    localparam logic [2:0] RATE_DEFAULT = 3'b100;
    localparam logic [1:0] BIAS_NONE    = 2'b00;
    localparam logic [1:0] BIAS_POS_XY  = 2'b01;
    localparam logic [1:0] BIAS_NEG_XY  = 2'b10;
    localparam logic [1:0] DRIVE_POS    = 2'b01;
    localparam logic [1:0] DRIVE_NEG    = 2'b10;

    // Output period in units of 1/300 s for each rate code
    function automatic int unsigned rate_units(input logic [2:0] code);
        case (code)
            3'b000:  return 400;
            3'b001:  return 200;
            3'b010:  return 100;
            3'b011:  return 40;
            3'b101:  return 10;
            3'b110:  return 4;
            default: return 20;
        endcase
    endfunction

    function automatic logic bias_active(input logic [1:0] code);
        return (code == BIAS_POS_XY) || (code == BIAS_NEG_XY);
    endfunction

    // Polarity of the bias current for one axis; Z is opposite to X and Y
    function automatic logic [1:0] bias_pol(input logic [1:0] code, input logic [1:0] axis);
        logic is_z;
        is_z = (axis == 2'd2);
        case (code)
            BIAS_POS_XY: return is_z ? DRIVE_NEG : DRIVE_POS;
            BIAS_NEG_XY: return is_z ? DRIVE_POS : DRIVE_NEG;
            default:     return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/msq_period_timer.sv
module msq_period_timer
    import msq_pkg::*;
#(
    parameter int CLK_PER_UNIT = 1000,
    parameter int CW = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       run,
    input  logic [2:0] rate,
    output logic       fire
);
    logic [CW-1:0] per;
    logic [CW-1:0] first_cnt;
    logic [CW-1:0] cnt_q;

    assign per       = CW'(rate_units(rate) * CLK_PER_UNIT);
    assign first_cnt = (per << 1) - CW'(1);

    always_ff @(posedge clk) begin
        if (rst || load || !run) begin
            cnt_q <= first_cnt;
        end else if (cnt_q == '0) begin
            cnt_q <= per - CW'(1);
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign fire = run && !load && (cnt_q == '0);

endmodule

// File: rtl/msq_axis_calc.sv
module msq_axis_calc
    import msq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int RB = RES_BITS
) (
    input  logic [DW-1:0] raw,
    input  logic          raw_ovf,
    input  logic [DW-1:0] first,
    input  logic          first_bad,
    input  logic          use_diff,
    output logic          raw_bad,
    output logic [DW-1:0] value
);
    localparam logic signed [DW:0] LO  = (DW+1)'(-(2 ** (RB - 1)));
    localparam logic signed [DW:0] HI  = (DW+1)'((2 ** (RB - 1)) - 1);
    localparam logic [DW-1:0]      SAT = DW'(-(2 ** RB));

    logic signed [DW:0] raw_x;
    logic signed [DW:0] first_x;
    logic signed [DW:0] diff;
    logic               diff_bad;
    logic               bad;

    always_comb begin
        raw_x    = {raw[DW-1], raw};
        first_x  = {first[DW-1], first};
        diff     = raw_x - first_x;
        raw_bad  = raw_ovf || (raw_x < LO) || (raw_x > HI);
        diff_bad = (diff < LO) || (diff > HI);
        bad      = use_diff ? (raw_bad || first_bad || diff_bad) : raw_bad;
        if (bad) begin
            value = SAT;
        end else if (use_diff) begin
            value = diff[DW-1:0];
        end else begin
            value = raw;
        end
    end

endmodule

// File: rtl/msq_conv_engine.sv
module msq_conv_engine
    import msq_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     pend,
    input  logic                     bus_busy,
    input  logic [1:0]               bias_code,
    input  logic                     adc_done,
    input  logic [DW-1:0]            adc_data,
    input  logic                     adc_ovf,
    output logic                     take,
    output logic                     adc_start,
    output logic [1:0]               adc_axis,
    output logic [1:0]               bias_drive,
    output logic                     seq_done,
    output logic [AXES-1:0][DW-1:0]  res_o,
    output logic                     res_strobe
);
    localparam logic [1:0] LAST_AXIS = 2'(AXES - 1);

    seq_state_e     state_q;
    logic [1:0]     axis_q;
    logic           phase_q;
    logic [DW-1:0]  first_q;
    logic           first_bad_q;
    logic           strobe_q;
    logic           biased;
    logic           bias_phase;
    logic           raw_bad;
    logic [DW-1:0]  val;
    logic           wr_stage;

    assign biased     = bias_active(bias_code);
    assign bias_phase = biased && phase_q;

    msq_axis_calc #(.DW(DW), .RB(RES_BITS)) u_calc (
        .raw       (adc_data),
        .raw_ovf   (adc_ovf),
        .first     (first_q),
        .first_bad (first_bad_q),
        .use_diff  (bias_phase),
        .raw_bad   (raw_bad),
        .value     (val)
    );

    assign take       = (state_q == ST_IDLE) && pend && !flush;
    assign adc_start  = (state_q == ST_REQ) && !bus_busy && !flush;
    assign adc_axis   = axis_q;
    assign bias_drive = ((state_q == ST_REQ || state_q == ST_WAIT) && bias_phase)
                        ? bias_pol(bias_code, axis_q) : 2'b00;
    assign seq_done   = (state_q == ST_DONE) && !flush;
    assign wr_stage   = !flush && (state_q == ST_WAIT) && adc_done && !(biased && !phase_q);
    assign res_strobe = strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            axis_q      <= 2'd0;
            phase_q     <= 1'b0;
            first_q     <= '0;
            first_bad_q <= 1'b0;
            strobe_q    <= 1'b0;
        end else begin
            strobe_q <= seq_done;
            if (flush) begin
                state_q <= ST_IDLE;
                phase_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: if (pend) begin
                        state_q <= ST_REQ;
                        axis_q  <= 2'd0;
                        phase_q <= 1'b0;
                    end
                    ST_REQ: if (!bus_busy) state_q <= ST_WAIT;
                    ST_WAIT: if (adc_done) begin
                        if (biased && !phase_q) begin
                            first_q     <= adc_data;
                            first_bad_q <= raw_bad;
                            phase_q     <= 1'b1;
                            state_q     <= ST_REQ;
                        end else begin
                            phase_q <= 1'b0;
                            if (axis_q == LAST_AXIS) begin
                                state_q <= ST_DONE;
                            end else begin
                                axis_q  <= axis_q + 2'd1;
                                state_q <= ST_REQ;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        logic [DW-1:0] stage_q;
        logic [DW-1:0] out_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
                out_q   <= '0;
            end else begin
                if (wr_stage && axis_q == 2'(g)) stage_q <= val;
                if (seq_done) out_q <= stage_q;
            end
        end
        assign res_o[g] = out_q;
    end

endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
    import msq_pkg::*;
#(
    parameter int CLK_PER_UNIT = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_wr,
    input  logic [1:0]  mode_wdata,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_rate,
    input  logic [1:0]  cfg_bias,
    input  logic        bus_busy,
    input  logic        adc_done,
    input  logic [15:0] adc_data,
    input  logic        adc_ovf,
    output logic        adc_start,
    output logic [1:0]  adc_axis,
    output logic [1:0]  bias_drive,
    output logic [1:0]  mode_field,
    output logic [15:0] res_x,
    output logic [15:0] res_y,
    output logic [15:0] res_z,
    output logic        res_strobe
);
    localparam int CW = $clog2(2 * MAX_UNITS * CLK_PER_UNIT + 1);

    mode_e      mode_q;
    mode_e      mode_next;
    logic [2:0] rate_q;
    logic [2:0] rate_next;
    logic [1:0] bias_q;
    logic       pend_q;
    logic       flush;
    logic       fire;
    logic       take;
    logic       seq_done;
    logic [AXES-1:0][DATA_W-1:0] res;

    assign flush     = mode_wr || cfg_wr;
    assign mode_next = mode_wr ? mode_e'(mode_wdata) : mode_q;
    assign rate_next = cfg_wr ? cfg_rate : rate_q;

    msq_period_timer #(.CLK_PER_UNIT(CLK_PER_UNIT), .CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (flush),
        .run  (mode_next == MODE_CONT),
        .rate (rate_next),
        .fire (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SINGLE;
            rate_q <= RATE_DEFAULT;
            bias_q <= BIAS_NONE;
            pend_q <= 1'b1;
        end else begin
            if (cfg_wr) begin
                rate_q <= cfg_rate;
                bias_q <= cfg_bias;
            end
            if (mode_wr) begin
                mode_q <= mode_e'(mode_wdata);
            end else if (seq_done && mode_q == MODE_SINGLE) begin
                mode_q <= MODE_SLEEP;
            end
            if (flush) begin
                pend_q <= (mode_next == MODE_SINGLE);
            end else if (fire) begin
                pend_q <= 1'b1;
            end else if (take) begin
                pend_q <= 1'b0;
            end
        end
    end

    msq_conv_engine #(.DW(DATA_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .pend       (pend_q),
        .bus_busy   (bus_busy),
        .bias_code  (bias_q),
        .adc_done   (adc_done),
        .adc_data   (adc_data),
        .adc_ovf    (adc_ovf),
        .take       (take),
        .adc_start  (adc_start),
        .adc_axis   (adc_axis),
        .bias_drive (bias_drive),
        .seq_done   (seq_done),
        .res_o      (res),
        .res_strobe (res_strobe)
    );

    assign mode_field = mode_q;
    assign res_x      = res[0];
    assign res_y      = res[1];
    assign res_z      = res[2];

endmodule

// File: rtl/msq_checker.sv
module msq_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_busy,
    input logic        adc_start,
    input logic [1:0]  bias_drive,
    input logic [1:0]  mode_field,
    input logic [15:0] res_x,
    input logic [15:0] res_y,
    input logic [15:0] res_z,
    input logic        res_strobe
);
    function automatic logic legal(input logic [15:0] v);
        return ($signed(v) >= -16'sd2048 && $signed(v) <= 16'sd2047) || (v == 16'hF000);
    endfunction

    p_bus_priority_r9: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> !bus_busy);

    p_drive_polarity_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bias_drive));

    p_quiet_modes_r6: assert property (@(posedge clk) disable iff (rst)
        mode_field[1] |-> !adc_start);

    p_single_to_sleep_r2: assert property (@(posedge clk) disable iff (rst)
        (res_strobe && $past(mode_field) == 2'b01) |-> mode_field == 2'b11);

    p_result_legal_r8: assert property (@(posedge clk) disable iff (rst)
        res_strobe |-> (legal(res_x) && legal(res_y) && legal(res_z)));

    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        res_strobe |=> !res_strobe);

endmodule

bind meas_sequencer msq_checker u_msq_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_busy   (bus_busy),
    .adc_start  (adc_start),
    .bias_drive (bias_drive),
    .mode_field (mode_field),
    .res_x      (res_x),
    .res_y      (res_y),
    .res_z      (res_z),
    .res_strobe (res_strobe)
);

// File: tb/meas_sequencer_bench.sv
`timescale 1ns/1ps
module meas_sequencer_bench;
    localparam int CPU = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wdata = 2'b00;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_rate = 3'b100;
    logic [1:0]  cfg_bias = 2'b00;
    logic        bus_busy = 1'b0;
    logic        adc_done = 1'b0;
    logic [15:0] adc_data = 16'h0;
    logic        adc_ovf = 1'b0;
    logic        adc_start;
    logic [1:0]  adc_axis;
    logic [1:0]  bias_drive;
    logic [1:0]  mode_field;
    logic [15:0] res_x, res_y, res_z;
    logic        res_strobe;

    meas_sequencer #(.CLK_PER_UNIT(CPU)) u_meas_sequencer (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cfg_wr(cfg_wr), .cfg_rate(cfg_rate), .cfg_bias(cfg_bias),
        .bus_busy(bus_busy), .adc_done(adc_done), .adc_data(adc_data),
        .adc_ovf(adc_ovf), .adc_start(adc_start), .adc_axis(adc_axis),
        .bias_drive(bias_drive), .mode_field(mode_field), .res_x(res_x),
        .res_y(res_y), .res_z(res_z), .res_strobe(res_strobe)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    // converter model stimulus
    int base [3];
    int add  [3];
    bit ov   [3];
    int nstart = 0;
    int st_n = 0;
    int st_cyc [16];
    int log_n = 0;
    int ax_log [16];
    int drv_log [16];
    int nstrobe = 0;

    initial begin
        int cnt;
        int v;
        cnt = 0;
        forever begin
            @(negedge clk);
            #2;
            adc_done = 1'b0;
            if (rst) begin
                cnt = 0;
            end else begin
                if (cnt > 0) begin
                    cnt--;
                    if (cnt == 0) adc_done = 1'b1;
                end
                if (adc_start) begin
                    v = base[adc_axis];
                    if (bias_drive == 2'b01) v = v + add[adc_axis];
                    if (bias_drive == 2'b10) v = v - add[adc_axis];
                    adc_data = v[15:0];
                    adc_ovf  = ov[adc_axis];
                    nstart++;
                    if (log_n < 16) begin
                        ax_log[log_n]  = int'(adc_axis);
                        drv_log[log_n] = int'(bias_drive);
                        log_n++;
                    end
                    if (adc_axis == 2'd0 && bias_drive == 2'b00 && st_n < 16) begin
                        st_cyc[st_n] = cyc;
                        st_n++;
                    end
                    cnt = 2;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (res_strobe) nstrobe++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic bit oob(input int v);
        return (v < -2048) || (v > 2047);
    endfunction

    function automatic int units(input logic [2:0] c);
        case (c)
            3'b000: return 400;
            3'b001: return 200;
            3'b010: return 100;
            3'b011: return 40;
            3'b101: return 10;
            3'b110: return 4;
            default: return 20;
        endcase
    endfunction

    function automatic int exp_axis(input int b0, input int ad, input bit ovf,
                                    input logic [1:0] bc, input int ax);
        int b1;
        bit pos;
        bit bad;
        if (bc == 2'b01 || bc == 2'b10) begin
            pos = (bc == 2'b01) ? (ax != 2) : (ax == 2);
            b1  = pos ? b0 + ad : b0 - ad;
            bad = ovf || oob(b0) || oob(b1) || oob(b1 - b0);
            return bad ? -4096 : b1 - b0;
        end
        bad = ovf || oob(b0);
        return bad ? -4096 : b0;
    endfunction

    task automatic do_mode(input logic [1:0] m, output int w);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
        w = cyc;
    endtask

    task automatic do_cfg(input logic [2:0] r, input logic [1:0] b);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_rate = r; cfg_bias = b;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_strobe(input int lim, output bit seen);
        seen = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (res_strobe) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic check_results(input string req, input logic [1:0] bc);
        int e;
        e = exp_axis(base[0], add[0], ov[0], bc, 0);
        chk($signed(res_x) == e, {req, " x"}, $signed(res_x), e);
        e = exp_axis(base[1], add[1], ov[1], bc, 1);
        chk($signed(res_y) == e, {req, " y"}, $signed(res_y), e);
        e = exp_axis(base[2], add[2], ov[2], bc, 2);
        chk($signed(res_z) == e, {req, " z"}, $signed(res_z), e);
    endtask

    task automatic set_axes(input int b0, input int b1, input int b2,
                            input int a0, input int a1, input int a2);
        base[0] = b0; base[1] = b1; base[2] = b2;
        add[0] = a0; add[1] = a1; add[2] = a2;
        ov[0] = 0; ov[1] = 0; ov[2] = 0;
    endtask

    task automatic timing_test(input logic [2:0] rc, input string tag);
        int w;
        int p;
        p = units(rc) * CPU;
        do_cfg(rc, 2'b00);
        st_n = 0;
        do_mode(2'b00, w);
        for (int i = 0; i < 6 * p && st_n < 3; i++) @(negedge clk);
        chk(st_n >= 3, {tag, " starts seen"}, st_n, 3);
        chk(st_cyc[0] - w == 2 * p + 1, {tag, " first start R3"}, st_cyc[0] - w, 2 * p + 1);
        chk(st_cyc[1] - st_cyc[0] == p, {tag, " spacing R4"}, st_cyc[1] - st_cyc[0], p);
        chk(st_cyc[2] - st_cyc[1] == p, {tag, " spacing R4"}, st_cyc[2] - st_cyc[1], p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        bit seen;
        int w;
        int n0;
        int s0;
        logic [1:0] bc;
        void'($urandom(32'd2024));
        set_axes(100, -200, 300, 0, 0, 0);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mode_field == 2'b01, "R1 mode after reset", mode_field, 1);
        chk(res_x == 16'h0 && res_y == 16'h0 && res_z == 16'h0, "R1 results zero", res_x, 0);
        chk(!res_strobe, "R1 strobe low", res_strobe, 0);
        log_n = 0;
        rst = 1'b0;
        // R1/R2: automatic one-shot after reset
        wait_strobe(200, seen);
        chk(seen, "R1 one-shot after reset", seen, 1);
        check_results("R2 reset shot", 2'b00);
        chk(mode_field == 2'b11, "R2 mode to sleep", mode_field, 3);
        chk(log_n == 3 && ax_log[0] == 0 && ax_log[1] == 1 && ax_log[2] == 2,
            "R2 axis order", ax_log[1], 1);

        // R7: bias polarity and phase order, code 01
        set_axes(10, 20, 30, 600, 600, 600);
        do_cfg(3'b100, 2'b01);
        log_n = 0;
        do_mode(2'b01, w);
        wait_strobe(200, seen);
        chk(seen, "R7 strobe code01", seen, 1);
        check_results("R7 code01", 2'b01);
        chk(drv_log[0] == 0 && drv_log[1] == 1 && drv_log[2] == 0 && drv_log[3] == 1
            && drv_log[4] == 0 && drv_log[5] == 2, "R7 drive sequence", drv_log[5], 2);
        // R7: reverse polarity, code 10
        do_cfg(3'b100, 2'b10);
        do_mode(2'b01, w);
        wait_strobe(200, seen);
        check_results("R7 code10", 2'b10);
        // R7: code 11 acts unbiased
        do_cfg(3'b100, 2'b11);
        do_mode(2'b01, w);
        wait_strobe(200, seen);
        check_results("R7 code11", 2'b11);

        // R8: overflow cases, then replacement by a valid shot
        set_axes(-2000, 5, 2100, 4000, 5, 5);
        ov[1] = 1;
        do_cfg(3'b100, 2'b01);
        do_mode(2'b01, w);
        wait_strobe(200, seen);
        chk($signed(res_x) == -4096, "R8 diff overflow", $signed(res_x), -4096);
        chk($signed(res_y) == -4096, "R8 adc flag", $signed(res_y), -4096);
        chk($signed(res_z) == -4096, "R8 range", $signed(res_z), -4096);
        set_axes(7, -8, 9, 0, 0, 0);
        do_cfg(3'b100, 2'b00);
        do_mode(2'b01, w);
        wait_strobe(200, seen);
        check_results("R8 replaced", 2'b00);

        // random one-shots
        for (int it = 0; it < 16; it++) begin
            bc = 2'($urandom % 4);
            for (int a = 0; a < 3; a++) begin
                if ($urandom % 4 != 0) base[a] = int'($urandom_range(0, 3999)) - 2000;
                else base[a] = int'($urandom_range(0, 5999)) - 3000;
                add[a] = int'($urandom_range(0, 1500));
                ov[a]  = ($urandom % 8 == 0);
            end
            do_cfg(3'($urandom % 8), bc);
            do_mode(2'b01, w);
            wait_strobe(200, seen);
            chk(seen, "R2 random strobe", seen, 1);
            check_results("R8 R7 random", bc);
            chk(mode_field == 2'b11, "R2 random sleep", mode_field, 3);
        end

        // R3/R4/R5 continuous timing
        set_axes(1, 2, 3, 0, 0, 0);
        timing_test(3'b110, "R5 code110");
        do_mode(2'b11, w);
        timing_test(3'b100, "R5 code100");
        do_mode(2'b10, w);
        timing_test(3'b111, "R5 code111");

        // R6: idle stops conversions
        do_mode(2'b10, w);
        repeat (3) @(negedge clk);
        n0 = nstart;
        repeat (600) @(negedge clk);
        chk(nstart == n0, "R6 idle no start", nstart - n0, 0);
        chk(mode_field == 2'b10, "R6 idle mode", mode_field, 2);
        do_mode(2'b11, w);
        n0 = nstart;
        repeat (400) @(negedge clk);
        chk(nstart == n0, "R6 sleep no start", nstart - n0, 0);

        // R9: bus priority holds off conversion
        set_axes(-50, 60, -70, 0, 0, 0);
        do_cfg(3'b100, 2'b00);
        @(negedge clk);
        bus_busy = 1'b1;
        n0 = nstart;
        s0 = nstrobe;
        do_mode(2'b01, w);
        repeat (40) @(negedge clk);
        chk(nstart == n0, "R9 held while busy", nstart - n0, 0);
        bus_busy = 1'b0;
        wait_strobe(200, seen);
        chk(seen, "R9 resumes", seen, 1);
        check_results("R9 result", 2'b00);

        // R10: write abandons a running sequence
        set_axes(11, 12, 13, 100, 100, 100);
        do_cfg(3'b100, 2'b01);
        n0 = nstart;
        do_mode(2'b01, w);
        for (int i = 0; i < 100 && nstart < n0 + 2; i++) @(negedge clk);
        s0 = nstrobe;
        do_mode(2'b10, w);
        repeat (100) @(negedge clk);
        chk(nstrobe == s0, "R10 no strobe after abort", nstrobe - s0, 0);
        chk(mode_field == 2'b10, "R10 mode kept", mode_field, 2);
        chk($signed(res_x) == -50, "R10 results unchanged", $signed(res_x), -50);

        finish_run();
    end

endmodule